// File: doc/BRIEF.md
# Programmable Square-Wave Output Generator

This block turns a 32.768 kHz timebase into a selectable square wave or a fixed level on one output pin. A 15-bit binary divider counts rising edges of the timebase. A small control register picks what the pin shows: either one of four divider taps, or a static level taken from a separate register bit. The pin is meant to sit behind an open-drain pad, so the block provides both the logical level and a pull-down enable.

The same divider also provides a 1 Hz reference for the timekeeping logic. The block raises a one-cycle pulse when that reference falls, and the calendar advances on that falling edge. When the 1 Hz rate is selected, the output's falling edge lines up with that pulse.

The timebase input is a level signal that is already synchronous to the system clock. The output register only updates on the clock after a timebase edge has been seen. A change of configuration therefore cannot cut a level short.

Top module: `sqw_gen`

## Requirements
- R1: After reset the control register reads 0x00, the output level is 0, the pull-down enable is 1 and the seconds-advance pulse is 0.
- R2: A control write keeps bit 7 (static level), bit 4 (wave enable) and bits 1:0 (rate code), and clears all other bits. The readback shows the stored value on the clock after the write.
- R3: With the wave enable set and rate code 11, the output period is one timebase period, with equal high and low times.
- R4: With rate code 10, the output period is four timebase periods (8.192 kHz), with equal high and low times.
- R5: With rate code 01, the output period is eight timebase periods (4.096 kHz), with equal high and low times.
- R6: With rate code 00, the output period is 32768 timebase periods (1 Hz), with equal high and low times.
- R7: With the wave enable clear, the output equals the static-level bit for both of its values, and the rate code has no effect on the output.
- R8: The seconds-advance output pulses for one clock when the 1 Hz reference falls. With rate code 00 selected, that pulse occurs in the same cycle as the output's falling edge.
- R9: The output level changes only on the clock after a timebase edge. Even while the configuration changes, no output level lasts less than half a timebase period.
- R10: The pull-down enable is asserted exactly when the output level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_i | input | 1 | 32.768 kHz timebase level, synchronous to clk |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_rdata_o | output | 8 | Control register readback |
| sqw_o | output | 1 | Output level (square wave or static) |
| sqw_pull_o | output | 1 | Open-drain pull-down enable, high when sqw_o is low |
| ref_1hz_o | output | 1 | 1 Hz reference from the top divider tap |
| sec_adv_o | output | 1 | One-cycle pulse on the falling edge of the 1 Hz reference |

## Verification
A stuck or mis-stepped divider bit shows as a wrong high or low time on the selected tap within one output period. The slow 1 Hz tap is the exception: it needs about 65536 timebase edges before its first falling edge can expose an error. A wrong tap index or rate decode appears as a wrong period after the first full cycle. A corrupted static-level or enable bit shows on the very next timebase edge. An output register that updates outside timebase edges shows up as a level shorter than half a timebase period whenever the configuration changes mid-phase.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

    typedef enum logic [1:0] {
        RATE_1HZ  = 2'b00,
        RATE_4K   = 2'b01,
        RATE_8K   = 2'b10,
        RATE_32K  = 2'b11
    } sqw_rate_e;

    typedef struct packed {
        logic      out_lvl;
        logic      wave_en;
        sqw_rate_e rate;
    } sqw_cfg_t;

    localparam int unsigned CFG_BIT_LVL = 7;
    localparam int unsigned CFG_BIT_EN  = 4;
    localparam logic [7:0]  CFG_MASK    = 8'h93;

    function automatic sqw_cfg_t cfg_from_byte(input logic [7:0] b);
        sqw_cfg_t c;
        c.out_lvl = b[CFG_BIT_LVL];
        c.wave_en = b[CFG_BIT_EN];
        c.rate    = sqw_rate_e'(b[1:0]);
        return c;
    endfunction

    function automatic logic [7:0] cfg_to_byte(input sqw_cfg_t c);
        logic [7:0] b;
        b              = 8'h00;
        b[CFG_BIT_LVL] = c.out_lvl;
        b[CFG_BIT_EN]  = c.wave_en;
        b[1:0]         = c.rate;
        return b;
    endfunction

endpackage

// File: rtl/sqw_cfg_reg.sv
module sqw_cfg_reg
    import sqw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [7:0] wdata_i,
    output sqw_cfg_t   cfg_o,
    output logic [7:0] rdata_o
);

    typedef struct packed {
        sqw_cfg_t cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.cfg = cfg_from_byte(wdata_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o   = st_q.cfg;
    assign rdata_o = cfg_to_byte(st_q.cfg);

    AST_CFG_WRITE_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (rdata_o == ($past(wdata_i) & CFG_MASK))); // R2

endmodule

// File: rtl/sqw_tbase_div.sv
module sqw_tbase_div #(
    parameter int unsigned DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_i,
    output logic             edge_o,
    output logic             lvl_nxt_o,
    output logic [DIV_W-1:0] cnt_nxt_o,
    output logic             ref_o,
    output logic             sec_o
);

    localparam int unsigned MSB = DIV_W - 1;
    localparam logic [DIV_W-1:0] CNT_TOP = {DIV_W{1'b1}};

    typedef struct packed {
        logic             osc;
        logic [DIV_W-1:0] cnt;
        logic             sec;
    } state_t;

    state_t st_d, st_q;
    logic   rise;

    always_comb begin
        st_d     = st_q;
        rise     = osc_i & ~st_q.osc;
        st_d.osc = osc_i;
        st_d.sec = 1'b0;
        if (rise) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.sec = (st_q.cnt == CNT_TOP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_o    = osc_i ^ st_q.osc;
    assign lvl_nxt_o = osc_i;
    assign cnt_nxt_o = st_d.cnt;
    assign ref_o     = st_q.cnt[MSB];
    assign sec_o     = st_q.sec;

    AST_DIV_STEPS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_i && !st_q.osc) |=> (st_q.cnt == DIV_W'($past(st_q.cnt) + 1'b1))); // R6
    AST_DIV_HOLDS_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !(osc_i && !st_q.osc) |=> $stable(st_q.cnt)); // R6
    AST_SEC_ON_REF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        sec_o |-> $fell(ref_o)); // R8
    AST_SEC_NOT_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_o) |-> sec_o); // R8

endmodule

// File: rtl/sqw_out_mux.sv
module sqw_out_mux
    import sqw_pkg::*;
#(
    parameter int unsigned DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             lvl_nxt_i,
    input  logic [DIV_W-1:0] cnt_nxt_i,
    input  sqw_cfg_t         cfg_i,
    output logic             sqw_o,
    output logic             pull_o
);

    localparam int unsigned TAP_8K  = 1;
    localparam int unsigned TAP_4K  = 2;
    localparam int unsigned TAP_1HZ = DIV_W - 1;

    typedef struct packed {
        logic lvl;
    } state_t;

    state_t st_d, st_q;
    logic   wave;

    always_comb begin
        unique case (cfg_i.rate)
            RATE_32K: wave = lvl_nxt_i;
            RATE_8K:  wave = cnt_nxt_i[TAP_8K];
            RATE_4K:  wave = cnt_nxt_i[TAP_4K];
            default:  wave = cnt_nxt_i[TAP_1HZ];
        endcase
        st_d = st_q;
        if (edge_i) begin
            st_d.lvl = cfg_i.wave_en ? wave : cfg_i.out_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sqw_o  = st_q.lvl;
    assign pull_o = ~st_q.lvl;

    AST_OUT_MOVES_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.lvl) |-> $past(edge_i)); // R9
    AST_STATIC_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !cfg_i.wave_en) |=> (sqw_o == $past(cfg_i.out_lvl))); // R7

endmodule

// File: rtl/sqw_gen.sv
module sqw_gen
    import sqw_pkg::*;
#(
    parameter int unsigned DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_i,
    input  logic       cfg_we_i,
    input  logic [7:0] cfg_wdata_i,
    output logic [7:0] cfg_rdata_o,
    output logic       sqw_o,
    output logic       sqw_pull_o,
    output logic       ref_1hz_o,
    output logic       sec_adv_o
);

    sqw_cfg_t         cfg;
    logic             tb_edge;
    logic             lvl_nxt;
    logic [DIV_W-1:0] cnt_nxt;

    sqw_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg),
        .rdata_o (cfg_rdata_o)
    );

    sqw_tbase_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_i     (osc_i),
        .edge_o    (tb_edge),
        .lvl_nxt_o (lvl_nxt),
        .cnt_nxt_o (cnt_nxt),
        .ref_o     (ref_1hz_o),
        .sec_o     (sec_adv_o)
    );

    sqw_out_mux #(.DIV_W(DIV_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (tb_edge),
        .lvl_nxt_i (lvl_nxt),
        .cnt_nxt_i (cnt_nxt),
        .cfg_i     (cfg),
        .sqw_o     (sqw_o),
        .pull_o    (sqw_pull_o)
    );

    AST_PULL_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_pull_o != sqw_o); // R10
    AST_1HZ_FALL_WITH_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.wave_en && cfg.rate == RATE_1HZ && $past(cfg.wave_en) && $past(cfg.rate) == RATE_1HZ && sec_adv_o) |-> $fell(sqw_o)); // R8

endmodule

// File: tb/sim_sqw_gen.sv
module sim_sqw_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       sqw, pull, ref1, sec;

    int n_checks = 0;
    int n_fail   = 0;
    int half     = 1;
    logic fall_sec;
    logic fall_ref;

    logic mon_en = 1'b0;
    logic mon_prev = 1'b0;
    logic mon_seen = 1'b0;
    int   mon_run = 0;
    int   mon_min = 1000000;

    always #4 clk = ~clk;

    initial begin
        forever begin
            repeat (half) @(negedge clk);
            osc = ~osc;
        end
    end

    sqw_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_i       (osc),
        .cfg_we_i    (cfg_we),
        .cfg_wdata_i (cfg_wdata),
        .cfg_rdata_o (cfg_rdata),
        .sqw_o       (sqw),
        .sqw_pull_o  (pull),
        .ref_1hz_o   (ref1),
        .sec_adv_o   (sec)
    );

    always @(negedge clk) begin
        if (!mon_en) begin
            mon_seen = 1'b0;
            mon_run  = 0;
        end else if (sqw != mon_prev) begin
            if (mon_seen && mon_run < mon_min) mon_min = mon_run;
            mon_seen = 1'b1;
            mon_run  = 1;
        end else begin
            mon_run++;
        end
        mon_prev = sqw;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic measure(input string req, input int exp_half);
        int hi = 0;
        int lo = 0;
        int guard = 0;
        logic prev;
        @(negedge clk);
        prev = sqw;
        while (!(prev == 1'b0 && sqw == 1'b1) && guard < 70000) begin
            prev = sqw;
            @(negedge clk);
            guard++;
        end
        while (sqw == 1'b1 && hi < 70000) begin
            hi++;
            @(negedge clk);
        end
        fall_sec = sec;
        fall_ref = ref1;
        while (sqw == 1'b0 && lo < 70000) begin
            lo++;
            @(negedge clk);
        end
        chk({req, " high time"}, hi, exp_half);
        chk({req, " low time"}, lo, exp_half);
    endtask

    task automatic test_reset;
        chk("R1 readback", cfg_rdata, 0);
        chk("R1 level", sqw, 0);
        chk("R1 pull", pull, 1);
        chk("R1 sec pulse", sec, 0);
    endtask

    task automatic test_one_hz;
        wr(8'h10);
        measure("R6 1Hz", 32768);
        chk("R8 sec pulse at output fall", fall_sec, 1);
        chk("R8 reference low at fall", fall_ref, 0);
    endtask

    task automatic test_readback;
        wr(8'hFF);
        chk("R2 reserved bits cleared", cfg_rdata, 8'h93);
        wr(8'h6C);
        chk("R2 only reserved bits written", cfg_rdata, 8'h00);
        wr(8'h12);
        chk("R2 enable and rate kept", cfg_rdata, 8'h12);
    endtask

    task automatic test_rates;
        wr(8'h13);
        measure("R3 32k", 1);
        wr(8'h12);
        measure("R4 8k", 4);
        wr(8'h11);
        measure("R5 4k", 8);
    endtask

    task automatic test_static;
        int changes;
        logic prev;
        wr(8'h83);
        repeat (6) @(negedge clk);
        chk("R7 static high", sqw, 1);
        chk("R10 pull off when high", pull, 0);
        changes = 0;
        prev = sqw;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sqw != prev) changes++;
            prev = sqw;
        end
        chk("R7 rate code ignored while static high", changes, 0);
        wr(8'h02);
        repeat (6) @(negedge clk);
        chk("R7 static low", sqw, 0);
        chk("R10 pull on when low", pull, 1);
        changes = 0;
        prev = sqw;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sqw != prev) changes++;
            prev = sqw;
        end
        chk("R7 rate code ignored while static low", changes, 0);
    endtask

    task automatic test_switching;
        logic [7:0] seq [8] = '{8'h13, 8'h10, 8'h12, 8'h80, 8'h11, 8'h13, 8'h00, 8'h12};
        int gaps [8] = '{1, 2, 5, 7, 4, 2, 3, 8};
        half = 3;
        repeat (12) @(negedge clk);
        mon_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            for (int r = 0; r < 4; r++) begin
                wr(seq[i]);
                repeat (gaps[(i + r) % 8]) @(negedge clk);
            end
        end
        repeat (30) @(negedge clk);
        mon_en = 1'b0;
        chk("R9 shortest level >= half timebase", (mon_min >= 3) ? 1 : 0, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_one_hz();
        test_readback();
        test_rates();
        test_static();
        test_switching();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule